// File: doc/BRIEF.md
# Twin-Bank Load/Store Merge Buffer

This block holds load/store operations between a load/store function unit and two L1 cache ports. The unit hands over its requests as pairs of operations, which together cover an access that crosses a 16-byte boundary. Address bit 4 of each operation picks its bank. The two operations of a pair always have opposite values of that bit, so one pair fills the left and the right half of a single row. The row's address bits above bit 11 are kept only once, and both halves share them.

Each bank picks its lowest-indexed pending entry. It folds in the byte masks of every higher entry in the same bank that targets the same 32-byte line with the same direction. It then presents one 128-bit byte-enabled read or write to its own L1 port. When the port accepts, every entry that took part is retired in that bank. A row becomes free again only once both of its halves have retired. Allocation stalls while all rows are reserved.

Top module: `twin_merge_buf`

## Requirements
- R1: After reset neither bank presents a request, and `alloc_ready` is high.
- R2: The operation whose address bit 4 is 0 goes to the left bank, and the one with bit 4 equal to 1 goes to the right bank. A request address carries the entry's bits 48..5, carries the bank value in bit 4, and has bits 3..0 zero.
- R3: In an allocated pair, the two operations have opposite values of address bit 4.
- R4: The byte mask of an entry is `((1 << size) - 1) << addr[3:0]`, kept to its low 16 bits.
- R5: Each bank presents the pending entry with the lowest row index.
- R6: The presented mask is the OR of the chosen entry's mask and the masks of all higher rows in that bank that match it in address bits 48..5 and in direction. The presented direction is the chosen entry's direction.
- R7: When a port accepts, the chosen entry and all entries merged into it leave that bank only. Non-matching entries remain and are presented later.
- R8: A row is free only when both of its halves have retired. `alloc_ready` is low exactly when no row is free. A new pair takes the lowest free row.
- R9: The banks operate independently. A presented request stays valid until its port accepts it.
- R10: Address bits 48..12 of a row are taken once, from operation `a`, and serve both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A pair of operations is offered |
| alloc_ready | output | 1 | A free row exists |
| a_addr | input | AW | Address of operation a |
| a_size | input | 5 | Byte count of operation a |
| a_we | input | 1 | Operation a is a write |
| b_addr | input | AW | Address of operation b |
| b_size | input | 5 | Byte count of operation b |
| b_we | input | 1 | Operation b is a write |
| lreq_valid | output | 1 | Left bank request valid |
| lreq_ready | input | 1 | Left L1 port accepts |
| lreq_addr | output | AW | Left request line address |
| lreq_we | output | 1 | Left request is a write |
| lreq_mask | output | 16 | Left byte enables |
| rreq_valid | output | 1 | Right bank request valid |
| rreq_ready | input | 1 | Right L1 port accepts |
| rreq_addr | output | AW | Right request line address |
| rreq_we | output | 1 | Right request is a write |
| rreq_mask | output | 16 | Right byte enables |

## Verification
Allocation of a new pair and acceptance of merged requests can fall in the same cycle. The retirement of the left half and the right half of one row can also coincide in one cycle. The bench provokes both cases by holding `alloc_valid` high while driving each port's ready from its own random stream. It runs this over a handful of upper and middle address values, so that matches, direction conflicts and full-buffer stalls all occur. Every cycle, an arithmetic reference model in the bench predicts each bank's valid, address, direction and merged mask, and it predicts `alloc_ready`.

// File: rtl/twin_merge_buf.sv
module twin_merge_buf #(
  parameter int ROWS = 8,
  parameter int AW   = 49
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [AW-1:0] a_addr,
  input  logic [4:0]    a_size,
  input  logic          a_we,
  input  logic [AW-1:0] b_addr,
  input  logic [4:0]    b_size,
  input  logic          b_we,
  output logic          lreq_valid,
  input  logic          lreq_ready,
  output logic [AW-1:0] lreq_addr,
  output logic          lreq_we,
  output logic [15:0]   lreq_mask,
  output logic          rreq_valid,
  input  logic          rreq_ready,
  output logic [AW-1:0] rreq_addr,
  output logic          rreq_we,
  output logic [15:0]   rreq_mask
);
  localparam int UW = AW - 12;
  localparam int IW = $clog2(ROWS);

  function automatic logic [15:0] span(input logic [3:0] off, input logic [4:0] sz);
    logic [31:0] m;
    m = ((32'd1 << sz) - 32'd1) << off;
    return m[15:0];
  endfunction

  logic [UW-1:0]   up  [ROWS];
  logic [6:0]      mid [2][ROWS];
  logic [15:0]     msk [2][ROWS];
  logic [ROWS-1:0] wrt [2];
  logic [ROWS-1:0] vld [2];

  logic [1:0]      found;
  logic [IW-1:0]   sel  [2];
  logic [ROWS-1:0] hit  [2];
  logic [15:0]     omsk [2];
  logic [1:0]      done;

  logic [ROWS-1:0] free;
  logic [IW-1:0]   frow;
  logic            fire;

  logic            a_left;
  logic [6:0]      in_mid [2];
  logic [15:0]     in_msk [2];
  logic            in_we  [2];

  assign a_left    = ~a_addr[4];
  assign in_mid[0] = a_left ? a_addr[11:5] : b_addr[11:5];
  assign in_mid[1] = a_left ? b_addr[11:5] : a_addr[11:5];
  assign in_msk[0] = a_left ? span(a_addr[3:0], a_size) : span(b_addr[3:0], b_size);
  assign in_msk[1] = a_left ? span(b_addr[3:0], b_size) : span(a_addr[3:0], a_size);
  assign in_we[0]  = a_left ? a_we : b_we;
  assign in_we[1]  = a_left ? b_we : a_we;

  assign free        = ~(vld[0] | vld[1]);
  assign alloc_ready = |free;
  assign fire        = alloc_valid & alloc_ready;

  always_comb begin
    frow = '0;
    for (int i = ROWS - 1; i >= 0; i--)
      if (free[i]) frow = IW'(i);
  end

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      found[b] = 1'b0;
      sel[b]   = '0;
      for (int i = ROWS - 1; i >= 0; i--)
        if (vld[b][i]) begin
          found[b] = 1'b1;
          sel[b]   = IW'(i);
        end
      omsk[b] = '0;
      for (int i = 0; i < ROWS; i++) begin
        hit[b][i] = vld[b][i] && (i >= int'(sel[b])) &&
                    (wrt[b][i] == wrt[b][sel[b]]) &&
                    (mid[b][i] == mid[b][sel[b]]) &&
                    (up[i] == up[sel[b]]);
        if (hit[b][i]) omsk[b] = omsk[b] | msk[b][i];
      end
    end
  end

  assign done = {rreq_ready & found[1], lreq_ready & found[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= '0;
      vld[1] <= '0;
    end else begin
      for (int b = 0; b < 2; b++)
        vld[b] <= (vld[b] & ~(hit[b] & {ROWS{done[b]}})) |
                  (fire ? (ROWS'(1) << frow) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      up[frow] <= a_addr[AW-1:12];
      for (int b = 0; b < 2; b++) begin
        mid[b][frow] <= in_mid[b];
        msk[b][frow] <= in_msk[b];
        wrt[b][frow] <= in_we[b];
      end
    end
  end

  assign lreq_valid = found[0];
  assign lreq_addr  = {up[sel[0]], mid[0][sel[0]], 1'b0, 4'h0};
  assign lreq_we    = wrt[0][sel[0]];
  assign lreq_mask  = omsk[0];
  assign rreq_valid = found[1];
  assign rreq_addr  = {up[sel[1]], mid[1][sel[1]], 1'b1, 4'h0};
  assign rreq_we    = wrt[1][sel[1]];
  assign rreq_mask  = omsk[1];

  a_r3_pair_split: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (a_addr[4] != b_addr[4]));
  a_r2_left_filled: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> lreq_valid);
  a_r2_right_filled: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> rreq_valid);
  a_r9_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && !lreq_ready) |=> lreq_valid);
  a_r9_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rreq_valid && !rreq_ready) |=> rreq_valid);
endmodule

// File: tb/twin_merge_buf_test.sv
module twin_merge_buf_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, alloc_valid, alloc_ready, a_we, b_we;
  logic [48:0] a_addr, b_addr, lreq_addr, rreq_addr;
  logic [4:0]  a_size, b_size;
  logic        lreq_valid, lreq_ready, lreq_we, rreq_valid, rreq_ready, rreq_we;
  logic [15:0] lreq_mask, rreq_mask;

  twin_merge_buf uut (.*);

  logic        q_v [2];
  logic [48:0] q_a [2];
  logic        q_w [2];
  logic [15:0] q_m [2];
  assign q_v[0] = lreq_valid; assign q_v[1] = rreq_valid;
  assign q_a[0] = lreq_addr;  assign q_a[1] = rreq_addr;
  assign q_w[0] = lreq_we;    assign q_w[1] = rreq_we;
  assign q_m[0] = lreq_mask;  assign q_m[1] = rreq_mask;

  bit          mv [2][8];
  logic [43:0] ml [2][8];
  logic [15:0] mm [2][8];
  bit          mw [2][8];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_mask(logic [3:0] off, logic [4:0] sz);
    logic [31:0] m;
    m = ((32'd1 << sz) - 32'd1) << off;
    return m[15:0];
  endfunction

  task automatic step(bit av, bit lr, bit rr);
    logic [36:0] up;
    logic [6:0]  am, bm;
    logic        a4;
    logic [3:0]  ao, bo;
    int          sel [2];
    bit          anyfree;
    int          frow;
    // R3: the two operations always get opposite bit 4
    up = ($urandom % 2) ? 37'h1 : 37'h5A;
    am = 7'($urandom % 2);
    bm = 7'($urandom % 2);
    a4 = 1'($urandom);
    ao = 4'($urandom);
    bo = 4'($urandom);
    alloc_valid = av;
    a_addr = {up, am, a4, ao};
    b_addr = {up, bm, ~a4, bo};
    a_size = 5'($urandom % 17);
    b_size = 5'($urandom % 17);
    a_we = 1'($urandom);
    b_we = 1'($urandom);
    lreq_ready = lr;
    rreq_ready = rr;
    #1;
    anyfree = 0; frow = 0;
    for (int i = 7; i >= 0; i--)
      if (!mv[0][i] && !mv[1][i]) begin anyfree = 1; frow = i; end
    chk("R8 alloc_ready", 64'(alloc_ready), 64'(anyfree));
    for (int b = 0; b < 2; b++) begin
      logic [15:0] em;
      sel[b] = -1;
      for (int i = 7; i >= 0; i--) if (mv[b][i]) sel[b] = i;
      chk("R5 R9 valid", 64'(q_v[b]), 64'(sel[b] >= 0));
      if (sel[b] >= 0) begin
        em = '0;
        for (int i = sel[b]; i < 8; i++)
          if (mv[b][i] && ml[b][i] == ml[b][sel[b]] && mw[b][i] == mw[b][sel[b]])
            em |= mm[b][i];
        chk("R2 R10 addr", 64'(q_a[b]), 64'({ml[b][sel[b]], 1'(b), 4'h0}));
        chk("R6 direction", 64'(q_w[b]), 64'(mw[b][sel[b]]));
        chk("R4 R6 mask", 64'(q_m[b]), 64'(em));
      end
    end
    // R7: retire chosen and merged entries on acceptance
    for (int b = 0; b < 2; b++)
      if (sel[b] >= 0 && ((b == 0) ? lr : rr)) begin
        int s = sel[b];
        logic [43:0] l = ml[b][s];
        bit w = mw[b][s];
        for (int i = s; i < 8; i++)
          if (mv[b][i] && ml[b][i] == l && mw[b][i] == w) mv[b][i] = 0;
      end
    if (av && anyfree) begin
      int la = a4 ? 1 : 0;
      mv[la][frow] = 1; ml[la][frow] = {up, am}; mm[la][frow] = expect_mask(ao, a_size); mw[la][frow] = a_we;
      mv[1-la][frow] = 1; ml[1-la][frow] = {up, bm}; mm[1-la][frow] = expect_mask(bo, b_size); mw[1-la][frow] = b_we;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 8; i++) mv[b][i] = 0;
    rst_n = 0; alloc_valid = 0; lreq_ready = 0; rreq_ready = 0;
    a_addr = '0; b_addr = '0; a_size = '0; b_size = '0; a_we = 0; b_we = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 left idle", 64'(lreq_valid), 64'(0));
    chk("R1 right idle", 64'(rreq_valid), 64'(0));
    chk("R1 ready", 64'(alloc_ready), 64'(1));
    // fill every row, then drain left only, then right (R8)
    for (int k = 0; k < 10; k++) step(1, 0, 0);
    for (int k = 0; k < 10; k++) step(1, 1, 0);
    for (int k = 0; k < 10; k++) step(0, 0, 1);
    // continuous allocation with acceptance in the same cycles
    for (int k = 0; k < 500; k++) step(1, 1, 1);
    for (int k = 0; k < 4000; k++)
      step(($urandom % 10) < 6, 1'($urandom), 1'($urandom));
    for (int k = 0; k < 20; k++) step(0, 1, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule